// File: doc/BRIEF.md
# Fractional Bit-Timing Recovery Sampler

This block sits in the front end of a low- or full-speed USB receiver and runs on the oversampling clock, one line sample per clock. From a start-of-packet pulse it places a bit-centre sampling instant half a bit after the first J-to-K transition. It then advances that instant by one bit period per bit. It also emits a strobe half a bit before each centre, at the point where a line transition would occur. The bit period and the sample position are both held as unsigned fixed-point values, so the sampler follows rates that are not an integer number of samples per bit.

When the decoder downstream reports a 0 bit, a transition was due in that bit. The symbol captured at the preceding edge point then shows whether the line changed early or late. If the edge sample already shows the new symbol, the clock is slow: the period is shortened and the phase pulled earlier. Otherwise the period is lengthened and the phase pushed later. The period is held within a band of ±3 % around nominal. Symbol decoding, NRZI decoding and bit unstuffing stay outside; the decoder feeds back the symbol and bit value it took at each centre strobe.

Top module: `bit_timing_recovery`

## Requirements
- R1: After reset, and until the first start pulse, neither sample_strobe nor edge_strobe is ever asserted.
- R2: The nominal period in 1/4096-sample units is (SAMPLE_HZ·4096)/bit rate: 12 Mb/s when low_speed=0, 1.5 Mb/s when low_speed=1. The mode is captured at the start pulse. Without correction, successive centre strobes lie exactly one period apart.
- R3: A start pulse in the cycle where the free-running sample count is c places the first centre at c + 1/2 + period/2 (period/2 rounded down in fixed point). sample_strobe fires in the cycle whose count equals the integer part: 2 cycles later at full speed, 16 at low speed, for a 48 MHz sample rate.
- R4: At each centre strobe the next edge point is set to (old position + period − period/2), using the period in force before any correction. Exactly one edge_strobe fires between two consecutive centre strobes, and never in the same cycle as one.
- R5: A centre strobe with dec_bit=1 changes neither period nor phase.
- R6: A centre strobe with dec_bit=0 whose stored edge symbol equals dec_sym lowers the period by period/1024. The new position is the stepped position minus (P/128 + P/512), where P is the lowered period.
- R7: A centre strobe with dec_bit=0 whose stored edge symbol differs from dec_sym raises the period by period/1024. The new position is the stepped position plus (P/128 + P/512), where P is the raised period.
- R8: No correction is made when the stored edge symbol is SE0 or SE1, whatever dec_bit is.
- R9: The period never leaves [nominal·97/100, nominal·103/100] (integer division) of the current mode; a correction that would cross a bound stops at the bound.
- R10: Symbol codes are 0=SE0, 1=J, 2=K, 3=SE1 for dec_sym and for the stored edge symbol. Line (dp,dm)=(0,0) is SE0 and (1,1) is SE1. At full speed (1,0) is J and (0,1) is K; at low speed these two are swapped. The edge symbol is taken from the line in the start cycle and in each edge_strobe cycle.
- R11: A start pulse while already running discards the current period and phase and realigns exactly as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one line sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| low_speed | input | 1 | 1 selects low-speed rate and polarity, captured at start |
| sop_start | input | 1 | One-cycle pulse in the sample where the J-to-K start transition was seen |
| dec_sym | input | 2 | Symbol decoded at the current centre strobe (0 SE0, 1 J, 2 K, 3 SE1) |
| dec_bit | input | 1 | Bit value decoded at the current centre strobe |
| sample_strobe | output | 1 | Bit-centre sampling strobe |
| edge_strobe | output | 1 | Edge-point strobe, half a bit before the next centre |

## Verification
A wrong period or phase word shows at the ports as a centre strobe that lands one cycle early or late. The first such strobe appears within one bit time of the fault, so each strobe is compared with a model in every cycle. A sign error in the trim direction or a missing clamp is slower to surface: the strobe spacing drifts by one cycle only after tens of bits. Long runs of forced early and forced late transitions are therefore needed before the spacing settles against a bound. A wrong edge-symbol capture or polarity map flips the trim direction, so it appears as strobe spacing that shrinks where it should grow.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [1:0] {
    LSYM_SE0 = 2'd0,
    LSYM_J   = 2'd1,
    LSYM_K   = 2'd2,
    LSYM_SE1 = 2'd3
  } lsym_e;

  // Line pair to symbol; the low-speed polarity swaps J and K.
  function automatic lsym_e line_symbol(input logic dp, input logic dm, input logic low);
    lsym_e s;
    case ({dp, dm})
      2'b00:   s = LSYM_SE0;
      2'b11:   s = LSYM_SE1;
      2'b10:   s = low ? LSYM_K : LSYM_J;
      default: s = low ? LSYM_J : LSYM_K;
    endcase
    return s;
  endfunction

  function automatic logic single_ended(input lsym_e s);
    return (s == LSYM_SE0) || (s == LSYM_SE1);
  endfunction

  // Period trim: about 0.1 % of the period.
  function automatic logic [31:0] trim_step(input logic [31:0] per);
    return per >> 10;
  endfunction

  // Phase nudge: about 1 % of the period (1/128 + 1/512).
  function automatic logic [31:0] phase_nudge(input logic [31:0] per);
    return (per >> 7) + (per >> 9);
  endfunction

endpackage

// File: rtl/brt_sample_counter.sv
module brt_sample_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/brt_period_track.sv
module brt_period_track #(
  parameter int           W      = 28,
  parameter logic [W-1:0] NOM_FS = W'(16384),
  parameter logic [W-1:0] NOM_LS = W'(131072)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         low_speed_in,
  input  logic         trim_en,
  input  logic         trim_dn,
  output logic [W-1:0] period,
  output logic [W-1:0] period_next,
  output logic         mode_low
);
  import brt_pkg::*;

  localparam logic [W-1:0] LO_FS = W'((64'(NOM_FS) * 64'd97)  / 64'd100);
  localparam logic [W-1:0] HI_FS = W'((64'(NOM_FS) * 64'd103) / 64'd100);
  localparam logic [W-1:0] LO_LS = W'((64'(NOM_LS) * 64'd97)  / 64'd100);
  localparam logic [W-1:0] HI_LS = W'((64'(NOM_LS) * 64'd103) / 64'd100);

  logic [W-1:0] period_q;
  logic         mode_q;
  logic [W-1:0] lo_bound, hi_bound, step;
  logic [31:0]  step32;
  logic [W-1:0] shrunk, grown;

  assign lo_bound = mode_q ? LO_LS : LO_FS;
  assign hi_bound = mode_q ? HI_LS : HI_FS;
  assign step32   = trim_step(32'(period_q));
  assign step     = W'(step32);
  assign shrunk   = period_q - step;
  assign grown    = period_q + step;

  always_comb begin
    period_next = period_q;
    if (load)
      period_next = low_speed_in ? NOM_LS : NOM_FS;
    else if (trim_en) begin
      if (trim_dn) period_next = (shrunk < lo_bound) ? lo_bound : shrunk;
      else         period_next = (grown  > hi_bound) ? hi_bound : grown;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= NOM_FS;
      mode_q   <= 1'b0;
    end else begin
      period_q <= period_next;
      if (load) mode_q <= low_speed_in;
    end
  end

  assign period   = period_q;
  assign mode_low = mode_q;

  AST_PERIOD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q >= lo_bound) && (period_q <= hi_bound)); // R9

  AST_TRIM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_en && trim_dn && !load && (period_q > lo_bound)) |=> (period_q < $past(period_q))); // R6

  AST_TRIM_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_en && !trim_dn && !load && (period_q < hi_bound)) |=> (period_q > $past(period_q))); // R7

endmodule

// File: rtl/brt_phase_step.sv
module brt_phase_step #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 12,
  localparam int W     = CNT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] count,
  input  logic             load,
  input  logic             adj_en,
  input  logic             adj_dn,
  input  logic [W-1:0]     period,
  input  logic [W-1:0]     period_next,
  output logic             sample_hit,
  output logic             edge_hit
);
  import brt_pkg::*;

  localparam logic [W-1:0] HALF_SAMPLE = W'(1) << (FRAC_W - 1);

  logic [W-1:0] pos_q, edge_q;
  logic [W-1:0] base, stepped, nudge;
  logic [31:0]  nudge32;

  assign base    = {count, {FRAC_W{1'b0}}} + HALF_SAMPLE;
  assign stepped = pos_q + period;
  assign nudge32 = phase_nudge(32'(period_next));
  assign nudge   = W'(nudge32);

  assign sample_hit = active && (pos_q[W-1:FRAC_W]  == count);
  assign edge_hit   = active && (edge_q[W-1:FRAC_W] == count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      edge_q <= '0;
    end else if (load) begin
      pos_q  <= base + (period_next >> 1);
      edge_q <= base;
    end else if (sample_hit) begin
      edge_q <= stepped - (period >> 1);
      if (adj_en) pos_q <= adj_dn ? (stepped - nudge) : (stepped + nudge);
      else        pos_q <= stepped;
    end
  end

  AST_CENTRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hit |=> !sample_hit); // R2

  AST_EDGE_OFF_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> !sample_hit); // R4

endmodule

// File: rtl/bit_timing_recovery.sv
module bit_timing_recovery #(
  parameter int SAMPLE_HZ = 48_000_000,
  parameter int FS_BPS    = 12_000_000,
  parameter int LS_BPS    = 1_500_000,
  parameter int FRAC_W    = 12,
  parameter int CNT_W     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_dp,
  input  logic       line_dm,
  input  logic       low_speed,
  input  logic       sop_start,
  input  logic [1:0] dec_sym,
  input  logic       dec_bit,
  output logic       sample_strobe,
  output logic       edge_strobe
);
  import brt_pkg::*;

  localparam int POS_W = CNT_W + FRAC_W;
  localparam logic [POS_W-1:0] NOM_FS =
    POS_W'((64'(SAMPLE_HZ) << FRAC_W) / 64'(FS_BPS));
  localparam logic [POS_W-1:0] NOM_LS =
    POS_W'((64'(SAMPLE_HZ) << FRAC_W) / 64'(LS_BPS));

  logic [CNT_W-1:0] count;
  logic [POS_W-1:0] period, period_next;
  logic             mode_low;
  logic             active_q;
  lsym_e            edge_sym_q;
  logic             sample_hit, edge_hit;
  logic             trim_en, trim_dn;
  logic             edge_unusable;

  brt_sample_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count)
  );

  assign edge_unusable = single_ended(edge_sym_q);
  assign trim_en = sample_hit && !sop_start && !dec_bit && !edge_unusable;
  assign trim_dn = (edge_sym_q == lsym_e'(dec_sym));

  brt_period_track #(.W(POS_W), .NOM_FS(NOM_FS), .NOM_LS(NOM_LS)) u_period (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (sop_start),
    .low_speed_in (low_speed),
    .trim_en      (trim_en),
    .trim_dn      (trim_dn),
    .period       (period),
    .period_next  (period_next),
    .mode_low     (mode_low)
  );

  brt_phase_step #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active_q),
    .count       (count),
    .load        (sop_start),
    .adj_en      (trim_en),
    .adj_dn      (trim_dn),
    .period      (period),
    .period_next (period_next),
    .sample_hit  (sample_hit),
    .edge_hit    (edge_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      edge_sym_q <= LSYM_J;
    end else if (sop_start) begin
      active_q   <= 1'b1;
      edge_sym_q <= line_symbol(line_dp, line_dm, low_speed);
    end else if (edge_hit) begin
      edge_sym_q <= line_symbol(line_dp, line_dm, mode_low);
    end
  end

  assign sample_strobe = sample_hit;
  assign edge_strobe   = edge_hit;

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_strobe && edge_strobe)); // R4

  AST_NO_TRIM_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !sop_start && dec_bit) |=> $stable(period)); // R5

  AST_NO_TRIM_ON_SE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !sop_start && edge_unusable) |=> $stable(period)); // R8

endmodule

// File: tb/tb_bit_timing_recovery.sv
module tb_bit_timing_recovery;

  localparam int    CLK_PERIOD = 10;
  localparam int    FRAC = 12;
  localparam longint MODC = 65536;
  localparam longint MODP = longint'(1) << 28;
  localparam longint NOMF = (longint'(48_000_000) * 4096) / 12_000_000;
  localparam longint NOML = (longint'(48_000_000) * 4096) / 1_500_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp = 1'b1, dm = 1'b0;
  logic       low_speed = 1'b0;
  logic       start = 1'b0;
  logic [1:0] dec_sym = 2'd1;
  logic       dec_bit = 1'b1;
  wire        sample_strobe, edge_strobe;

  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  longint m_cnt = 0, m_pos = 0, m_edge = 0, m_per = NOMF;
  bit     m_act = 1'b0, m_low = 1'b0;
  int     m_esym = 1;

  bit_timing_recovery dut (
    .clk(clk), .rst_n(rst_n), .line_dp(dp), .line_dm(dm),
    .low_speed(low_speed), .sop_start(start), .dec_sym(dec_sym),
    .dec_bit(dec_bit), .sample_strobe(sample_strobe), .edge_strobe(edge_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sym_of(bit p, bit m, bit low);
    if (!p && !m) return 0;
    if (p && m)   return 3;
    if (p)        return low ? 2 : 1;
    return low ? 1 : 2;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model, advanced at every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_pos = 0; m_edge = 0; m_per = NOMF;
      m_act = 0; m_low = 0; m_esym = 1;
    end else begin
      bit hs, he;
      longint nom, lo, hi, nxt, nd;
      hs = m_act && (((m_pos >> FRAC) % MODC) == m_cnt);
      he = m_act && (((m_edge >> FRAC) % MODC) == m_cnt);
      if (start) begin
        m_act  = 1;
        m_low  = low_speed;
        m_per  = low_speed ? NOML : NOMF;
        m_edge = (m_cnt * 4096 + 2048) % MODP;
        m_pos  = (m_edge + m_per / 2) % MODP;
        m_esym = sym_of(dp, dm, low_speed);
      end else begin
        if (hs) begin
          nxt    = (m_pos + m_per) % MODP;
          m_edge = (nxt - m_per / 2 + MODP) % MODP;
          if (!dec_bit && m_esym != 0 && m_esym != 3) begin
            nom = m_low ? NOML : NOMF;
            lo  = nom * 97 / 100;
            hi  = nom * 103 / 100;
            if (m_esym == int'(dec_sym)) begin
              m_per = m_per - m_per / 1024;
              if (m_per < lo) m_per = lo;
              nd = m_per / 128 + m_per / 512;
              m_pos = (nxt - nd + MODP) % MODP;
            end else begin
              m_per = m_per + m_per / 1024;
              if (m_per > hi) m_per = hi;
              nd = m_per / 128 + m_per / 512;
              m_pos = (nxt + nd) % MODP;
            end
          end else begin
            m_pos = nxt;
          end
        end
        if (he) m_esym = sym_of(dp, dm, m_low);
      end
      m_cnt = (m_cnt + 1) % MODC;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit es, ee;
      es = m_act && (((m_pos >> FRAC) % MODC) == m_cnt);
      ee = m_act && (((m_edge >> FRAC) % MODC) == m_cnt);
      check(sample_strobe === es, cur_req, "sample_strobe vs model", longint'(sample_strobe), longint'(es));
      check(edge_strobe === ee, cur_req, "edge_strobe vs model", longint'(edge_strobe), longint'(ee));
    end
  end

  // observe n centre strobes: min/max spacing and edge strobes in between
  task automatic watch(int n, output int mn, output int mx, output int edges);
    int seen = 0, last = 0;
    mn = 1 << 30; mx = 0; edges = 0;
    while (seen < n) begin
      @(negedge clk);
      if (edge_strobe && seen > 0) edges++;
      if (sample_strobe) begin
        if (seen > 0) begin
          if (cyc - last < mn) mn = cyc - last;
          if (cyc - last > mx) mx = cyc - last;
        end
        last = cyc;
        seen++;
      end
    end
  endtask

  // pulse start with the given line state; return cycles to first centre strobe
  task automatic restart(bit p, bit m, bit low, output int lat);
    int t0;
    @(negedge clk);
    dp = p; dm = m; low_speed = low; start = 1'b1; t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    while (!sample_strobe) @(negedge clk);
    lat = cyc - t0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int mn, mx, ed, lat, any;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet before any start
    cur_req = "R1";
    any = 0;
    repeat (60) begin
      @(negedge clk);
      if (sample_strobe || edge_strobe) any++;
    end
    check(any == 0, "R1", "strobes before start", any, 0);

    // R3: full-speed alignment, line goes K
    cur_req = "R3";
    dec_bit = 1'b1; dec_sym = 2'd1;
    restart(1'b0, 1'b1, 1'b0, lat);
    check(lat == 2, "R3", "full-speed first centre latency", lat, 2);

    // R2 / R4 / R5: dec_bit=1 with mismatching symbol, exact spacing
    cur_req = "R5";
    watch(40, mn, mx, ed);
    check(mn == 4 && mx == 4, "R2", "nominal spacing min", mn, 4);
    check(mx == 4, "R5", "no trim on 1 bits max spacing", mx, 4);
    check(ed == 39, "R4", "edge strobes between 40 centres", ed, 39);

    // R6 / R9: forced early transitions (edge K equals dec_sym K)
    cur_req = "R6";
    dec_bit = 1'b0; dec_sym = 2'd2;
    watch(300, mn, mx, ed);
    check(mn < 4, "R6", "spacing shrinks below nominal", mn, 3);
    cur_req = "R9";
    watch(100, mn, mx, ed);
    check(mn >= 3, "R9", "floor keeps spacing", mn, 3);

    // R11 / R7 / R9: restart mid-run then forced late transitions
    cur_req = "R11";
    dec_sym = 2'd1;
    restart(1'b0, 1'b1, 1'b0, lat);
    check(lat == 2, "R11", "restart realigns", lat, 2);
    cur_req = "R7";
    watch(300, mn, mx, ed);
    check(mx > 4, "R7", "spacing grows above nominal", mx, 5);
    cur_req = "R9";
    watch(100, mn, mx, ed);
    check(mx <= 5, "R9", "ceiling keeps spacing", mx, 5);

    // R8: SE0 and SE1 at the edge point, dec_bit=0
    cur_req = "R8";
    restart(1'b0, 1'b0, 1'b0, lat);
    watch(40, mn, mx, ed);
    check(mn == 4 && mx == 4, "R8", "no trim on SE0 edge", mx, 4);
    restart(1'b1, 1'b1, 1'b0, lat);
    watch(40, mn, mx, ed);
    check(mn == 4 && mx == 4, "R8", "no trim on SE1 edge", mn, 4);

    // R10: low-speed polarity, (1,0) is K, dec_sym K -> shrink
    cur_req = "R10";
    dec_sym = 2'd2;
    restart(1'b1, 1'b0, 1'b1, lat);
    check(lat == 16, "R3", "low-speed first centre latency", lat, 16);
    watch(40, mn, mx, ed);
    check(mn < 32, "R10", "low-speed map gives early correction", mn, 31);
    check(mx <= 32, "R10", "low-speed spacing not grown", mx, 32);

    // R11: restart at an arbitrary point of a low-speed bit
    cur_req = "R11";
    repeat (7) @(negedge clk);
    restart(1'b1, 1'b0, 1'b1, lat);
    check(lat == 16, "R11", "mid-bit restart latency", lat, 16);
    watch(10, mn, mx, ed);
    check(ed == 9, "R4", "low-speed edge strobes between centres", ed, 9);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule